// File: doc/BRIEF.md
# Processor Start-Up Sequencer

This block controls the start-up of an 8-bit processor core with a 16-bit address bus. It watches an active-low processor reset input, cpu_res_ni, and passes it through a two-flop synchronizer. A low level must then hold for two consecutive synchronized samples before it counts as a reset. While the reset holds, the core is kept idle. Once the reset input returns high, the block runs a fixed seven-cycle bus sequence, during which it owns the address bus and the read/write line.

The sequence starts with two dummy reads. Three stack-page reads follow; no write reaches the bus, but the core's stack pointer still steps down once on each of them. The last two cycles read the start vector, low byte first, from the top two bytes of the address space. On the cycle after that, the assembled vector goes to the core's program counter and the first opcode fetch takes place at that address. A separate strobe tells the core to clear its decimal-mode flag and set its interrupt-disable flag. The block initializes no other register. The ready input stalls the sequence cycle by cycle, but it has no effect while reset is held.

Top module: `boot_sequencer`

## Requirements
- R1: cpu_res_ni passes two synchronizer flops before use. A low level that lasts for fewer than two consecutive synchronized samples is ignored, both in normal running and in the middle of a sequence.
- R2: While a qualified reset is held, core_hold_o is 1, addr_o is 16'hFFFF and no strobe is asserted. ready_i has no effect in this state.
- R3: After the synchronized reset input goes high, and with ready_i high, the seven sequence cycles place these values on addr_o: 16'hFFFF in cycles 1 and 2, {8'h01, sp_i} in cycles 3 to 5, 16'hFFFC in cycle 6 and 16'hFFFD in cycle 7.
- R4: sp_dec_o pulses once in each of cycles 3, 4 and 5, so a completed sequence lowers the stack pointer by exactly three.
- R5: rw_o stays 1 (read) in every cycle. No write is ever issued.
- R6: The vector is little-endian: pc_o = {byte read at 16'hFFFD, byte read at 16'hFFFC}. In the one cycle after cycle 7, fetch_o and pc_load_o are both 1 and addr_o equals pc_o.
- R7: stat_init_o is 1 during sequence cycle 1 and at no other time. It tells the core to set decimal mode to 0 and interrupt disable to 1.
- R8: When ready_i is low during sequence cycles 1 to 7, the sequence holds its current cycle. addr_o stays unchanged and no byte is captured.
- R9: A qualified reset during the sequence aborts it and returns the block to the hold state. No fetch follows until a complete sequence has run.
- R10: After the fetch cycle, core_hold_o is 0, addr_o is 0 and all strobes stay low until the next qualified reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| cpu_res_ni | input | 1 | Processor reset input, active low, asynchronous to clk_i |
| ready_i | input | 1 | 1 lets the sequence advance; 0 stalls it |
| data_i | input | 8 | Read data from the bus |
| sp_i | input | 8 | Current stack pointer of the core |
| addr_o | output | 16 | Address bus |
| rw_o | output | 1 | 1 = read, 0 = write |
| core_hold_o | output | 1 | Keeps the core idle |
| sp_dec_o | output | 1 | Tells the core to decrement its stack pointer |
| stat_init_o | output | 1 | Tells the core to clear decimal mode and set interrupt disable |
| pc_load_o | output | 1 | Tells the core to load its program counter from pc_o |
| pc_o | output | 16 | Assembled start vector |
| fetch_o | output | 1 | Marks the first opcode fetch |

## Verification
A wrong step count or a wrong phase shows up on addr_o during the same cycle. For example, a stack address can appear where a vector address belongs, or the hold state can end early. The per-cycle reference comparison therefore catches it within one clock. A wrong byte order or a missed capture only becomes visible at the fetch cycle, through pc_o and addr_o. A miscounted stack step becomes visible in the stack pointer total at the end of the sequence. A qualification counter that is off by one changes whether a one- or two-cycle pulse reaches core_hold_o, which is visible two to three cycles after the pulse.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_HOLD  = 2'd1,
    PH_SEQ   = 2'd2,
    PH_FETCH = 2'd3
  } phase_e;
endpackage

// File: rtl/boot_rst_qual.sv
module boot_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic res_ni,
  output logic rs_o,
  output logic qual_o
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       low_cnt_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= res_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign rs_o = sync_q[SYNC_STAGES-1];

  // consecutive synchronized low samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            low_cnt_q <= '0;
    else if (rs_o)                          low_cnt_q <= '0;
    else if (low_cnt_q < CNT_W'(MIN_LOW))   low_cnt_q <= low_cnt_q + 1'b1;

  assign qual_o = !rs_o && (low_cnt_q >= CNT_W'(MIN_LOW - 1));
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int SEQ_LEN = 7,
  localparam int STEP_W = $clog2(SEQ_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rs_i,
  input  logic              qual_i,
  input  logic              ready_i,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o
);
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      step_q  <= STEP_W'(1);
    end else if (qual_i) begin
      phase_q <= PH_HOLD;
      step_q  <= STEP_W'(1);
    end else begin
      unique case (phase_q)
        PH_HOLD: if (rs_i) begin
          phase_q <= PH_SEQ;
          step_q  <= STEP_W'(1);
        end
        PH_SEQ: if (ready_i) begin
          if (step_q == STEP_W'(SEQ_LEN)) phase_q <= PH_FETCH;
          else                            step_q  <= step_q + 1'b1;
        end
        PH_FETCH: phase_q <= PH_RUN;
        default:  phase_q <= PH_RUN;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
endmodule

// File: rtl/boot_vec_cap.sv
module boot_vec_cap #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_lo_i,
  input  logic          cap_hi_i,
  input  logic [DW-1:0] data_i,
  output logic [2*DW-1:0] vec_o
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= data_i;
      if (cap_hi_i) hi_q <= data_i;
    end

  assign vec_o = {hi_q, lo_q};
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          AW          = 2 * DW,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_LOW     = 2,
  parameter int          DUMMY_N     = 2,
  parameter int          STACK_N     = 3,
  parameter logic [AW-1:0] VEC_ADDR  = 16'hFFFC,
  parameter logic [AW-1:0] DUMMY_ADDR = 16'hFFFF,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_res_ni,
  input  logic          ready_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] sp_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic          core_hold_o,
  output logic          sp_dec_o,
  output logic          stat_init_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic          fetch_o
);
  localparam int SEQ_LEN  = DUMMY_N + STACK_N + 2;
  localparam int STEP_W   = $clog2(SEQ_LEN + 1);
  localparam int LO_STEP  = DUMMY_N + STACK_N + 1;
  localparam int HI_STEP  = SEQ_LEN;

  logic              rs_sync, qual;
  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic              in_seq, advance, is_dummy, is_stack, is_lo, is_hi;
  logic [AW-1:0]     vec;

  boot_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .res_ni(cpu_res_ni),
    .rs_o(rs_sync), .qual_o(qual)
  );

  boot_seq_fsm #(.SEQ_LEN(SEQ_LEN)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rs_i(rs_sync), .qual_i(qual),
    .ready_i(ready_i), .phase_o(phase), .step_o(step)
  );

  assign in_seq   = (phase == PH_SEQ);
  assign advance  = in_seq && ready_i && !qual;
  assign is_dummy = (step <= STEP_W'(DUMMY_N));
  assign is_stack = (step > STEP_W'(DUMMY_N)) && (step <= STEP_W'(DUMMY_N + STACK_N));
  assign is_lo    = (step == STEP_W'(LO_STEP));
  assign is_hi    = (step == STEP_W'(HI_STEP));

  boot_vec_cap #(.DW(DW)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_lo_i(advance && is_lo), .cap_hi_i(advance && is_hi),
    .data_i(data_i), .vec_o(vec)
  );

  always_comb begin
    addr_o = '0;
    unique case (phase)
      PH_HOLD:  addr_o = DUMMY_ADDR;
      PH_SEQ: begin
        if (is_dummy)      addr_o = DUMMY_ADDR;
        else if (is_stack) addr_o = {STACK_PAGE, sp_i};
        else if (is_lo)    addr_o = VEC_ADDR;
        else               addr_o = VEC_ADDR + 1'b1;
      end
      PH_FETCH: addr_o = vec;
      default:  addr_o = '0;
    endcase
  end

  assign rw_o        = 1'b1;
  assign core_hold_o = (phase == PH_HOLD) || in_seq;
  assign sp_dec_o    = advance && is_stack;
  assign stat_init_o = in_seq && (step == STEP_W'(1));
  assign fetch_o     = (phase == PH_FETCH);
  assign pc_load_o   = (phase == PH_FETCH);
  assign pc_o        = vec;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFC,
  parameter logic [AW-1:0] DUMMY_ADDR = 16'hFFFF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_i,
  input logic          rs_i,
  input logic [AW-1:0] addr_i,
  input logic          hold_i,
  input logic          sp_dec_i,
  input logic          stat_i,
  input logic          fetch_i
);
  assert_fetch_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |=> !fetch_i);

  assert_fetch_after_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> $past(addr_i) == VEC_ADDR + 1'b1);

  assert_stack_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_dec_i |-> (addr_i[AW-1:8] == 8'h01) && hold_i);

  assert_hold_on_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs_i && $past(!rs_i)) |=> hold_i);

  assert_stall_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !ready_i && rs_i) |=> $stable(addr_i));

  assert_stat_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i |-> hold_i && (addr_i == DUMMY_ADDR));
endmodule

bind boot_sequencer boot_seq_chk #(.AW(AW), .VEC_ADDR(VEC_ADDR), .DUMMY_ADDR(DUMMY_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .rs_i(rs_sync),
  .addr_i(addr_o), .hold_i(core_hold_o), .sp_dec_i(sp_dec_o),
  .stat_i(stat_init_o), .fetch_i(fetch_o)
);

// File: tb/sim_boot_sequencer.sv
`timescale 1ns/1ps
module sim_boot_sequencer;
  logic clk = 1'b0, rst_n = 1'b0, res_n = 1'b0, rdy = 1'b1;
  logic [7:0]  sp = 8'hFD, data;
  logic [7:0]  vlo = 8'h34, vhi = 8'h12;
  logic [15:0] addr, pc;
  logic rw, hold, sp_dec, stat, pc_load, fetch;
  int checks = 0, fails = 0, fetch_cnt = 0, hold_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  boot_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_res_ni(res_n), .ready_i(rdy),
    .data_i(data), .sp_i(sp), .addr_o(addr), .rw_o(rw), .core_hold_o(hold),
    .sp_dec_o(sp_dec), .stat_init_o(stat), .pc_load_o(pc_load), .pc_o(pc),
    .fetch_o(fetch)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    if (a == 16'hFFFC) return vlo;
    if (a == 16'hFFFD) return vhi;
    return a[7:0] ^ 8'h5A;
  endfunction
  assign data = mem(addr);

  always @(posedge clk) if (rst_n && sp_dec) sp <= sp - 8'd1;

  // reference model: ph 0 run, 1 hold, 2 sequence, 3 fetch
  int q1, q2, lowr, ph, k;
  logic [7:0] mlo, mhi;
  bit m_q, m_rs;

  function automatic bit m_qual();
    return (q2 == 0) && (lowr >= 1);
  endfunction

  function automatic logic [15:0] m_addr();
    if (ph == 1) return 16'hFFFF;
    if (ph == 2) begin
      if (k <= 2) return 16'hFFFF;
      if (k <= 5) return {8'h01, sp};
      if (k == 6) return 16'hFFFC;
      return 16'hFFFD;
    end
    if (ph == 3) return {mhi, mlo};
    return 16'h0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 = 0; q2 = 0; lowr = 0; ph = 1; k = 1; mlo = 0; mhi = 0;
    end else begin
      m_q = m_qual(); m_rs = (q2 != 0);
      if (m_q) begin ph = 1; k = 1; end
      else if (ph == 1) begin if (m_rs) begin ph = 2; k = 1; end end
      else if (ph == 2) begin
        if (rdy) begin
          if (k == 6) mlo = mem(m_addr());
          if (k == 7) begin mhi = mem(m_addr()); ph = 3; end
          else k++;
        end
      end else if (ph == 3) ph = 0;
      lowr = m_rs ? 0 : (lowr < 2 ? lowr + 1 : 2);
      q2 = q1; q1 = int'(res_n);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 addr", 32'(addr), 32'(m_addr()));
    chk("R5 rw", 32'(rw), 32'd1);
    chk("R2 hold", 32'(hold), 32'(ph == 1 || ph == 2));
    chk("R4 sp_dec", 32'(sp_dec), 32'(ph == 2 && k >= 3 && k <= 5 && rdy && !m_qual()));
    chk("R7 stat_init", 32'(stat), 32'(ph == 2 && k == 1));
    chk("R6 fetch", 32'(fetch), 32'(ph == 3));
    chk("R6 pc_load", 32'(pc_load), 32'(ph == 3));
    if (ph == 3) chk("R6 pc", 32'(pc), 32'({mhi, mlo}));
    if (fetch) fetch_cnt++;
    if (hold) hold_seen++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int f0;
    logic [7:0] s0;
    tick(3); rst_n = 1'b1;
    // R2: ready ignored during held reset
    rdy = 1'b0; tick(3);
    chk("R2 hold while ready low", 32'(hold), 32'd1);
    chk("R2 idle address", 32'(addr), 32'hFFFF);
    rdy = 1'b1; s0 = sp; f0 = fetch_cnt;
    res_n = 1'b1; tick(14);
    chk("R6 vector 1234", 32'(pc), 32'h1234);
    chk("R6 one fetch", 32'(fetch_cnt - f0), 32'd1);
    chk("R4 sp minus three", 32'(8'(s0 - sp)), 32'd3);
    chk("R10 run hold", 32'(hold), 32'd0);
    chk("R10 run addr", 32'(addr), 32'd0);
    // R8: stalls, two-cycle reset, new vector
    vlo = 8'hCD; vhi = 8'hAB; s0 = sp; f0 = fetch_cnt;
    res_n = 1'b0; tick(2); res_n = 1'b1;
    for (int i = 0; i < 30; i++) begin rdy = (i % 3) != 1; tick(1); end
    rdy = 1'b1; tick(4);
    chk("R8 vector ABCD under stalls", 32'(pc), 32'hABCD);
    chk("R8 one fetch", 32'(fetch_cnt - f0), 32'd1);
    chk("R8 sp minus three", 32'(8'(s0 - sp)), 32'd3);
    // R1: one-cycle pulse in run ignored
    hold_seen = 0;
    res_n = 1'b0; tick(1); res_n = 1'b1; tick(8);
    chk("R1 short pulse ignored", 32'(hold_seen), 32'd0);
    // R1: one-cycle pulse mid-sequence ignored
    vlo = 8'h00; vhi = 8'h80; f0 = fetch_cnt; s0 = sp;
    res_n = 1'b0; tick(3); res_n = 1'b1; tick(5);
    res_n = 1'b0; tick(1); res_n = 1'b1; tick(12);
    chk("R1 mid pulse vector", 32'(pc), 32'h8000);
    chk("R1 mid pulse sp", 32'(8'(s0 - sp)), 32'd3);
    chk("R1 mid pulse one fetch", 32'(fetch_cnt - f0), 32'd1);
    // R9: qualified reset aborts sequence
    vlo = 8'h55; vhi = 8'h66; f0 = fetch_cnt;
    res_n = 1'b0; tick(3); res_n = 1'b1; tick(5);
    res_n = 1'b0; tick(3);
    chk("R9 aborted no fetch", 32'(fetch_cnt - f0), 32'd0);
    chk("R9 back in hold", 32'(hold), 32'd1);
    res_n = 1'b1; tick(14);
    chk("R9 restart one fetch", 32'(fetch_cnt - f0), 32'd1);
    chk("R9 restart vector", 32'(pc), 32'h6655);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule